// File: doc/BRIEF.md
# Multicycle Processor Controller with Datapath

This block is a hardwired state-machine controller for a 32-bit load/store processor that takes several clock cycles per instruction. The processor has one memory port shared by instruction fetch and data access, and one ALU. That ALU advances the program counter, forms addresses and branch targets, and performs the register arithmetic. Each controller state lasts exactly one clock. Every intermediate value is parked in a holding register between states: the instruction word, the memory read word, the two operand latches and the ALU result latch. The next state can therefore rely on stable inputs.

The datapath is part of the block, so the controller can be exercised end to end from its memory port. That datapath is a register file with a hardwired zero register, a sign extender, the operand multiplexers and the ALU. The surrounding system supplies a word memory with combinational read data. It accepts a write on the clock edge that ends a cycle in which the write strobe is high. The supported operations are register-to-register arithmetic, word load, word store, branch on equal and absolute jump. Instructions take 2, 3, 4 or 5 clocks, depending on their class.

Top module: `mcyc_cpu`

## Requirements
- R1: In the fetch state, the read strobe is high, the write strobe is low and the address equals the program counter. At the end of that cycle the fetched word is held as the current instruction and the program counter advances by 4. The following fetch address reflects that increment unless a branch or jump changes it.
- R2: The state after fetch is always decode. Decode drives neither memory strobe. It latches the registers indexed by instruction bits 25..21 and 20..16. It also computes PC + (sign-extended bits 15..0 shifted left by 2) into the result latch. For instructions other than branches, this branch target has no visible effect.
- R3: Register-to-register instructions use opcode (bits 31..26) 0x00 and take 4 clocks: fetch, decode, execute and completion. Neither of the last two cycles touches memory. The result is written to the register indexed by bits 15..11.
- R4: The function field (bits 5..0) selects the ALU operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-on-less-than. The internal ALU codes are AND 000, OR 001, add 010, subtract 110 and set-less-than 111. Any other function value adds.
- R5: A load (opcode 0x23) takes 5 clocks. Its fourth clock reads memory at the base register (bits 25..21) plus the sign-extended 16-bit offset. Its fifth clock writes the read word to the register indexed by bits 20..16.
- R6: A store (opcode 0x2B) takes 4 clocks. In its fourth clock the write strobe is high, the address is base plus sign-extended offset, and the write data is the register indexed by bits 20..16.
- R7: A branch on equal (opcode 0x04) takes 3 clocks and subtracts the two operands. Only when they are equal does the PC become PC+4 plus the sign-extended offset shifted left by 2. Otherwise the PC stays at PC+4.
- R8: A jump (opcode 0x02) takes 3 clocks. The new PC is the upper 4 bits of PC+4, followed by bits 25..0, followed by two zero bits.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode returns to fetch right after decode (2 clocks). It changes no register and no memory.
- R11: While reset (active low, asynchronous) is held, the controller is in fetch with PC = 0, so the read strobe is high at address 0. All holding registers and register-file entries clear.
- R12: The read and write strobes are never high together. After every instruction, the next state is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_wdata | output | 32 | Store data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Combinational read data from memory |

## Verification
A behavioural instruction-level model predicts, for every clock, whether memory is read or written, at which address and with which data. A wrong cycle count for any class therefore shifts every later bus event and is caught at once. The program covers these cases:
- A negative base offset on a load. Missing sign extension would read far from address 0.
- A branch that falls through and one taken over a store. A wrong comparison or a mis-scaled offset would execute the skipped store.
- A jump over a store.
- Signed set-less-than with a negative operand. An unsigned compare would invert the result.
- A write to register 0, followed by a store of register 0. A missing zero guard would store a non-zero value.
- An undefined opcode. A decoder that lets it reach an execute state would add cycles or touch memory.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   typedef enum logic [3:0] {
      ST_FETCH, ST_DECODE, ST_MEMADR, ST_MEMRD, ST_MEMWB,
      ST_MEMWR, ST_REXEC, ST_RDONE, ST_BEQ, ST_JMP
   } state_e;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_J     = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   localparam logic [2:0] ALU_AND = 3'b000;
   localparam logic [2:0] ALU_OR  = 3'b001;
   localparam logic [2:0] ALU_ADD = 3'b010;
   localparam logic [2:0] ALU_SUB = 3'b110;
   localparam logic [2:0] ALU_SLT = 3'b111;

   typedef enum logic [1:0] {SB_REG, SB_FOUR, SB_SEXT, SB_SEXT_SH} srcb_e;
   typedef enum logic [1:0] {PS_ALU, PS_HOLD, PS_JUMP} pcsel_e;
   typedef enum logic [1:0] {AM_ADD, AM_SUB, AM_FUNCT} alumode_e;

   typedef struct packed {
      logic     pc_we;
      logic     pc_cond;
      pcsel_e   pc_sel;
      logic     addr_from_res;
      logic     mem_rd;
      logic     mem_wr;
      logic     ir_we;
      logic     mdr_we;
      logic     opnd_we;
      logic     res_we;
      logic     srca_reg;
      srcb_e    srcb;
      alumode_e alu_mode;
      logic     rf_we;
      logic     dst_rd_field;
      logic     wb_from_mem;
   } ctrl_t;

endpackage

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
   import mcyc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] opcode,
   output state_e     state,
   output ctrl_t      ctl
);

   state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      nxt = ST_FETCH;
      unique case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OP_LW, OP_SW: nxt = ST_MEMADR;
               OP_RTYPE:     nxt = ST_REXEC;
               OP_BEQ:       nxt = ST_BEQ;
               OP_J:         nxt = ST_JMP;
               default:      nxt = ST_FETCH;
            endcase
         end
         ST_MEMADR: nxt = (opcode == OP_LW) ? ST_MEMRD : ST_MEMWR;
         ST_MEMRD:  nxt = ST_MEMWB;
         ST_REXEC:  nxt = ST_RDONE;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_comb begin
      ctl = '0;
      ctl.pc_sel   = PS_ALU;
      ctl.srcb     = SB_REG;
      ctl.alu_mode = AM_ADD;
      unique case (state)
         ST_FETCH: begin
            ctl.mem_rd = 1'b1;
            ctl.ir_we  = 1'b1;
            ctl.pc_we  = 1'b1;
            ctl.srcb   = SB_FOUR;
         end
         ST_DECODE: begin
            ctl.opnd_we = 1'b1;
            ctl.res_we  = 1'b1;
            ctl.srcb    = SB_SEXT_SH;
         end
         ST_MEMADR: begin
            ctl.res_we   = 1'b1;
            ctl.srca_reg = 1'b1;
            ctl.srcb     = SB_SEXT;
         end
         ST_MEMRD: begin
            ctl.mem_rd        = 1'b1;
            ctl.addr_from_res = 1'b1;
            ctl.mdr_we        = 1'b1;
         end
         ST_MEMWB: begin
            ctl.rf_we       = 1'b1;
            ctl.wb_from_mem = 1'b1;
         end
         ST_MEMWR: begin
            ctl.mem_wr        = 1'b1;
            ctl.addr_from_res = 1'b1;
         end
         ST_REXEC: begin
            ctl.srca_reg = 1'b1;
            ctl.alu_mode = AM_FUNCT;
            ctl.res_we   = 1'b1;
         end
         ST_RDONE: begin
            ctl.rf_we        = 1'b1;
            ctl.dst_rd_field = 1'b1;
         end
         ST_BEQ: begin
            ctl.srca_reg = 1'b1;
            ctl.alu_mode = AM_SUB;
            ctl.pc_cond  = 1'b1;
            ctl.pc_sel   = PS_HOLD;
         end
         ST_JMP: begin
            ctl.pc_we  = 1'b1;
            ctl.pc_sel = PS_JUMP;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mcyc_aluctl.sv
module mcyc_aluctl
   import mcyc_pkg::*;
(
   input  alumode_e   mode,
   input  logic [5:0] funct,
   output logic [2:0] code
);

   always_comb begin
      unique case (mode)
         AM_SUB:   code = ALU_SUB;
         AM_FUNCT: begin
            case (funct)
               FN_SUB:  code = ALU_SUB;
               FN_AND:  code = ALU_AND;
               FN_OR:   code = ALU_OR;
               FN_SLT:  code = ALU_SLT;
               default: code = ALU_ADD;
            endcase
         end
         default:  code = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
   import mcyc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   code,
   output logic [W-1:0] y,
   output logic         zero
);

   logic [W-1:0] diff;
   logic         lt;

   assign diff = a - b;
   assign lt   = $signed(a) < $signed(b);

   always_comb begin
      case (code)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SUB: y = diff;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
   parameter int unsigned W              = 32,
   parameter int unsigned N              = 32,
   parameter int unsigned AW             = $clog2(N),
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);

   logic [W-1:0] regs [1:N-1];
   logic         wr_ok;

   assign wr_ok = we && (wa != '0);

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 1; i < N; i++) regs[i] <= '0;
            end else if (wr_ok) begin
               regs[wa] <= wd;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (rst_n && wr_ok) regs[wa] <= wd;
         end
      end
   endgenerate

   assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
   assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mcyc_cpu.sv
module mcyc_cpu
   import mcyc_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned NREG     = 32,
   parameter bit          RF_CLEAR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   output logic            mem_rd,
   output logic            mem_wr,
   input  logic [XLEN-1:0] mem_rdata
);

   localparam int unsigned RAW  = $clog2(NREG);
   localparam int unsigned IMMW = 16;
   localparam int unsigned JTW  = 26;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mcyc_cpu: XLEN must be 32 for the fixed instruction layout");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("mcyc_cpu: NREG must be 32 to match 5-bit register fields");
      end
   endgenerate

   state_e fsm_st;
   ctrl_t  ctl;

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
   logic [XLEN-1:0] sext, alu_a, alu_b, alu_y, pc_next, rf_wd;
   logic [XLEN-1:0] rf_rd1, rf_rd2;
   logic [RAW-1:0]  rf_wa;
   logic [2:0]      alu_code;
   logic            alu_zero, pc_load;

   mcyc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir_q[31:26]),
      .state  (fsm_st),
      .ctl    (ctl)
   );

   mcyc_aluctl u_aluctl (
      .mode  (ctl.alu_mode),
      .funct (ir_q[5:0]),
      .code  (alu_code)
   );

   mcyc_alu #(.W(XLEN)) u_alu (
      .a    (alu_a),
      .b    (alu_b),
      .code (alu_code),
      .y    (alu_y),
      .zero (alu_zero)
   );

   mcyc_regfile #(.W(XLEN), .N(NREG), .CLEAR_ON_RESET(RF_CLEAR)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (ir_q[25:21]),
      .ra2   (ir_q[20:16]),
      .rd1   (rf_rd1),
      .rd2   (rf_rd2),
      .we    (ctl.rf_we),
      .wa    (rf_wa),
      .wd    (rf_wd)
   );

   assign sext  = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
   assign alu_a = ctl.srca_reg ? a_q : pc_q;

   always_comb begin
      unique case (ctl.srcb)
         SB_FOUR:    alu_b = XLEN'(4);
         SB_SEXT:    alu_b = sext;
         SB_SEXT_SH: alu_b = {sext[XLEN-3:0], 2'b00};
         default:    alu_b = b_q;
      endcase
   end

   always_comb begin
      unique case (ctl.pc_sel)
         PS_HOLD: pc_next = res_q;
         PS_JUMP: pc_next = {pc_q[XLEN-1:XLEN-4], ir_q[JTW-1:0], 2'b00};
         default: pc_next = alu_y;
      endcase
   end

   assign pc_load   = ctl.pc_we || (ctl.pc_cond && alu_zero);
   assign rf_wa     = ctl.dst_rd_field ? ir_q[15:11] : ir_q[20:16];
   assign rf_wd     = ctl.wb_from_mem ? mdr_q : res_q;
   assign mem_addr  = ctl.addr_from_res ? res_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ir_q  <= '0;
         mdr_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
      end else begin
         if (pc_load)     pc_q  <= pc_next;
         if (ctl.ir_we)   ir_q  <= mem_rdata;
         if (ctl.mdr_we)  mdr_q <= mem_rdata;
         if (ctl.opnd_we) begin
            a_q <= rf_rd1;
            b_q <= rf_rd2;
         end
         if (ctl.res_we)  res_q <= alu_y;
      end
   end

endmodule

// File: rtl/mcyc_cpu_chk.sv
module mcyc_cpu_chk
   import mcyc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input state_e      st,
   input logic [31:0] pc_q,
   input logic [31:0] ir_q,
   input logic [31:0] a_q,
   input logic [31:0] b_q,
   input logic [31:0] mem_addr,
   input logic        mem_rd,
   input logic        mem_wr
);

   assert_fetch_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH) |-> (mem_rd && !mem_wr && mem_addr == pc_q));

   assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH) |=> (pc_q == $past(pc_q) + 32'd4));

   assert_decode_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH) |=> (st == ST_DECODE));

   assert_write_only_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (st == ST_MEMWR));

   assert_branch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BEQ && a_q != b_q) |=> $stable(pc_q));

   assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_JMP) |=> (pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00}));

   assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_back_to_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDONE || st == ST_MEMWB || st == ST_MEMWR || st == ST_BEQ || st == ST_JMP)
      |=> (st == ST_FETCH));

endmodule

bind mcyc_cpu mcyc_cpu_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st       (fsm_st),
   .pc_q     (pc_q),
   .ir_q     (ir_q),
   .a_q      (a_q),
   .b_q      (b_q),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr)
);

// File: tb/test_mcyc_cpu.sv
module test_mcyc_cpu;

   localparam int MWORDS = 64;
   localparam int RUN    = 220;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr;
   logic [31:0] mem [MWORDS];

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mcyc_cpu i_mcyc_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_rdata (mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[7:2]];

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] e_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] e_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic int op_len(logic [5:0] op);
      case (op)
         6'h00:   return 4;
         6'h23:   return 5;
         6'h2B:   return 4;
         6'h04:   return 3;
         6'h02:   return 3;
         default: return 2;
      endcase
   endfunction

   function automatic string op_tag(logic [5:0] op);
      case (op)
         6'h00:   return "R3";
         6'h23:   return "R5";
         6'h2B:   return "R6";
         6'h04:   return "R7";
         6'h02:   return "R8";
         default: return "R10";
      endcase
   endfunction

   // behavioural instruction-level model
   logic [31:0] pcm, irm, mdrm;
   logic [31:0] rm [32];
   int step = 0;
   int len  = 0;

   task automatic model_cycle();
      logic [5:0]  op;
      logic [4:0]  rs, rt, rd;
      logic [31:0] sx, ea, res;
      chk(!(mem_rd && mem_wr), "R12", {30'd0, mem_rd, mem_wr}, 32'd0);
      if (step == 0) begin
         chk(mem_rd && !mem_wr, "R1", {30'd0, mem_rd, mem_wr}, 32'd2);
         chk(mem_addr == pcm, "R1", mem_addr, pcm);
         irm  = mem[pcm[7:2]];
         pcm  = pcm + 32'd4;
         len  = op_len(irm[31:26]);
         step = 1;
         return;
      end
      op = irm[31:26]; rs = irm[25:21]; rt = irm[20:16]; rd = irm[15:11];
      sx = {{16{irm[15]}}, irm[15:0]};
      ea = rm[rs] + sx;
      if (op == 6'h23 && step == 3) begin
         chk(mem_rd && !mem_wr, "R5", {30'd0, mem_rd, mem_wr}, 32'd2);
         chk(mem_addr == ea, "R5", mem_addr, ea);
         mdrm = mem[ea[7:2]];
      end else if (op == 6'h2B && step == 3) begin
         chk(!mem_rd && mem_wr, "R6", {30'd0, mem_rd, mem_wr}, 32'd1);
         chk(mem_addr == ea, "R6", mem_addr, ea);
         chk(mem_wdata == rm[rt], "R6", mem_wdata, rm[rt]);
      end else begin
         chk(!mem_rd && !mem_wr, (step == 1) ? "R2" : op_tag(op), {30'd0, mem_rd, mem_wr}, 32'd0);
      end
      if (step == len - 1) begin
         case (op)
            6'h00: begin
               case (irm[5:0])
                  6'h22:   res = rm[rs] - rm[rt];
                  6'h24:   res = rm[rs] & rm[rt];
                  6'h25:   res = rm[rs] | rm[rt];
                  6'h2A:   res = ($signed(rm[rs]) < $signed(rm[rt])) ? 32'd1 : 32'd0;
                  default: res = rm[rs] + rm[rt];
               endcase
               if (rd != 5'd0) rm[rd] = res;
            end
            6'h23: if (rt != 5'd0) rm[rt] = mdrm;
            6'h04: if (rm[rs] == rm[rt]) pcm = pcm + {sx[29:0], 2'b00};
            6'h02: pcm = {pcm[31:28], irm[25:0], 2'b00};
            default: ;
         endcase
         step = 0;
      end else begin
         step++;
      end
   endtask

   logic [31:0] word0;

   initial begin
      for (int i = 0; i < MWORDS; i++) mem[i] = 32'd0;
      for (int i = 0; i < 32; i++) rm[i] = 32'd0;
      mem[0]  = e_i(6'h23, 5'd0, 5'd1, 16'h0080);
      mem[1]  = e_i(6'h23, 5'd0, 5'd2, 16'h0084);
      mem[2]  = e_r(5'd1, 5'd2, 5'd3, 6'h20);
      mem[3]  = e_r(5'd1, 5'd2, 5'd4, 6'h22);
      mem[4]  = e_r(5'd1, 5'd2, 5'd5, 6'h24);
      mem[5]  = e_r(5'd1, 5'd2, 5'd6, 6'h25);
      mem[6]  = e_r(5'd2, 5'd1, 5'd7, 6'h2A);
      mem[7]  = e_r(5'd1, 5'd2, 5'd8, 6'h2A);
      mem[8]  = e_r(5'd1, 5'd1, 5'd0, 6'h20);
      mem[9]  = e_i(6'h04, 5'd3, 5'd1, 16'd5);
      mem[10] = e_i(6'h04, 5'd1, 5'd1, 16'd1);
      mem[11] = e_i(6'h2B, 5'd0, 5'd1, 16'h00BC);
      mem[12] = e_i(6'h2B, 5'd0, 5'd3, 16'h0090);
      mem[13] = e_i(6'h2B, 5'd0, 5'd4, 16'h0094);
      mem[14] = e_i(6'h2B, 5'd0, 5'd5, 16'h0098);
      mem[15] = e_i(6'h2B, 5'd0, 5'd6, 16'h009C);
      mem[16] = e_i(6'h2B, 5'd0, 5'd7, 16'h00A0);
      mem[17] = e_i(6'h2B, 5'd0, 5'd8, 16'h00A4);
      mem[18] = e_i(6'h2B, 5'd0, 5'd0, 16'h00A8);
      mem[19] = 32'hFC00_0000;
      mem[20] = {6'h02, 26'd22};
      mem[21] = e_i(6'h2B, 5'd0, 5'd1, 16'h00B8);
      mem[22] = e_i(6'h2B, 5'd0, 5'd1, 16'h00AC);
      mem[23] = e_i(6'h23, 5'd3, 5'd9, 16'hFFFC);
      mem[24] = e_i(6'h2B, 5'd0, 5'd9, 16'h00B0);
      mem[25] = {6'h02, 26'd25};
      mem[32] = 32'd7;
      mem[33] = 32'hFFFF_FFFD;
      mem[42] = 32'h55;
      mem[46] = 32'h55;
      mem[47] = 32'h55;
      word0   = mem[0];
      pcm     = 32'd0;

      repeat (3) @(negedge clk);
      // R11: reset holds fetch at address 0
      chk(mem_rd === 1'b1 && mem_wr === 1'b0, "R11", {30'd0, mem_rd, mem_wr}, 32'd2);
      chk(mem_addr === 32'd0, "R11", mem_addr, 32'd0);
      rst_n = 1'b1;

      for (int c = 0; c < RUN; c++) begin
         model_cycle();
         @(negedge clk);
      end

      chk(mem[36] == 32'd4,          "R4",  mem[36], 32'd4);
      chk(mem[37] == 32'd10,         "R4",  mem[37], 32'd10);
      chk(mem[38] == 32'd5,          "R4",  mem[38], 32'd5);
      chk(mem[39] == 32'hFFFF_FFFF,  "R4",  mem[39], 32'hFFFF_FFFF);
      chk(mem[40] == 32'd1,          "R4",  mem[40], 32'd1);
      chk(mem[41] == 32'd0,          "R3",  mem[41], 32'd0);
      chk(mem[42] == 32'd0,          "R9",  mem[42], 32'd0);
      chk(mem[43] == 32'd7,          "R6",  mem[43], 32'd7);
      chk(mem[44] == word0,          "R5",  mem[44], word0);
      chk(mem[46] == 32'h55,         "R8",  mem[46], 32'h55);
      chk(mem[47] == 32'h55,         "R7",  mem[47], 32'h55);
      chk(step == 1 || step == 2 || step == 0, "R10", step, 32'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule